// File: doc/BRIEF.md
# Incrementing Burst Splitter with 4 KB Page Guard

This block sits on the manager side of a memory bus. It takes one transfer request (start address, total byte count and a size code giving 2^size bytes per beat) and turns it into a series of incrementing burst commands. Each command carries an address, a length field (beats minus one) and a size field.

Every command is cut at whichever limit comes first: the end of the current 4 KB page, the end of the transfer, or the largest beat count the selected mode allows. Commands leave one at a time over a valid/ready handshake. A one-cycle done pulse marks the acceptance of the last command. Requests that are misaligned or empty are refused with a one-cycle error pulse.

Top module: `burst_splitter4k`

## Requirements
- R1: No command spans a 4 KB page: cmd_addr[11:0] plus (cmd_len+1)·2^cmd_size never exceeds 4096. A transfer that reaches a page end is split there, so the next command starts exactly on the page boundary.
- R2: Every command has cmd_burst = 2'b01 (incrementing), and cmd_size equals the size code of the request. Each beat moves 2^size bytes.
- R3: With LONG_MODE=1 (the default), a command holds at most 256 beats (cmd_len ≤ 255).
- R4: With LONG_MODE=0, a command holds at most 16 beats (cmd_len ≤ 15).
- R5: A transfer that fits inside one page and within the beat cap goes out as exactly one command.
- R6: The beat count of each command is the smallest of three values: the beats still owed, the beats left before the next 4 KB boundary, and the mode cap.
- R7: The first command starts at the request address. Each later command starts at the previous address plus its beats·2^size. The beats of all commands add up to bytes/2^size.
- R8: A request whose address or byte count is not a multiple of 2^size, or whose byte count is zero, is refused. req_err is high for one cycle, in the cycle after acceptance, and no command follows.
- R9: req_ready is high only while no transfer is in progress. A request offered while busy is ignored and does not change the commands in flight.
- R10: While cmd_valid is high and cmd_ready is low, cmd_valid stays high and cmd_addr, cmd_len and cmd_size do not change.
- R11: done is high for exactly one cycle, in the cycle after the final command is accepted. cmd_valid is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Transfer request offered |
| req_ready | output | 1 | Splitter is idle and can take a request |
| req_addr | input | ADDR_W | Start byte address |
| req_bytes | input | CNT_W | Total bytes to move |
| req_size | input | 3 | Beat size code, 2^size bytes per beat |
| req_err | output | 1 | One-cycle pulse: the last request was refused |
| cmd_valid | output | 1 | Burst command present |
| cmd_ready | input | 1 | Downstream takes the command |
| cmd_addr | output | ADDR_W | Burst start address |
| cmd_len | output | 8 | Beats minus one |
| cmd_size | output | 3 | Beat size code |
| cmd_burst | output | 2 | Burst type, always 2'b01 |
| done | output | 1 | One-cycle pulse after the final command is accepted |

## Verification
The bench drives transfers of several kinds and compares every command with a model built from R6 and R7:
- one that fits in a page, to check that no split is made;
- one that crosses a page, to check that the cut lands exactly on the boundary;
- one that is long but page-aligned, so only the 256-beat cap applies;
- one that ends exactly on a page boundary, to expose off-by-one errors in the page-room arithmetic;
- one that runs over several pages, where page cuts and cap cuts alternate.

Backpressure stalls show whether a command is held steady while it waits. The other cases separate as follows:
- Misaligned and zero-length requests show whether the refusal path is reached.
- A request offered mid-transfer shows whether requests are ignored while the splitter is busy.
- A second instance in legacy mode shows whether the 16-beat cap is applied.

// File: rtl/bsplit_pkg.sv
// Shared constants for the 4 KB burst splitter.
// Assumes a fixed 4 KB page and 8-bit length fields.
package bsplit_pkg;
    localparam int          PAGE_BITS  = 12;
    localparam int          PAGE_BYTES = 1 << PAGE_BITS;
    localparam int          LEN_W      = 8;
    localparam int          BEAT_W     = LEN_W + 1;
    localparam logic [1:0]  BURST_INCR = 2'b01;

    // Beat cap for the chosen mode.
    function automatic int unsigned beat_cap(input bit long_mode);
        return long_mode ? 256 : 16;
    endfunction
endpackage

// File: rtl/bsplit_req_check.sv
// Request qualifier: says whether a request can be split.
// A request is usable when its address and byte count are both multiples of
// 2^size and the byte count is not zero. Assumes size <= 7, ADDR_W >= 7 and CNT_W >= 7.
module bsplit_req_check #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  bytes,
    input  logic [2:0]        size,
    output logic              ok
);
    logic [6:0] low_mask;

    // Build the mask of the address bits below the beat size, then test both operands against it.
    always_comb begin
        low_mask = 7'((8'd1 << size) - 8'd1);
        ok = ((addr[6:0] & low_mask) == 7'd0) &&
             ((bytes[6:0] & low_mask) == 7'd0) &&
             (bytes != '0);
    end
endmodule

// File: rtl/bsplit_beat_calc.sv
// Beat count for the current command: the smallest of the beats still owed,
// the beats left in the current 4 KB page, and the mode cap.
// Assumes the page offset is a multiple of 2^size.
module bsplit_beat_calc
    import bsplit_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter bit LONG_MODE = 1'b1
) (
    input  logic [PAGE_BITS-1:0] page_off,
    input  logic [CNT_W-1:0]     rem_beats,
    input  logic [2:0]           size,
    output logic [BEAT_W-1:0]    beats
);
    localparam int CW       = ((CNT_W > PAGE_BITS + 1) ? CNT_W : PAGE_BITS + 1) + 1;
    localparam int MAX_BEAT = int'(beat_cap(LONG_MODE));

    logic [PAGE_BITS:0] room_bytes;
    logic [CW-1:0]      room_beats;
    logic [CW-1:0]      owed;
    logic [CW-1:0]      cap;
    logic [CW-1:0]      pick;

    // Compare the three limits and keep the smallest.
    always_comb begin
        room_bytes = (PAGE_BITS+1)'(PAGE_BYTES) - {1'b0, page_off};
        room_beats = CW'(room_bytes >> size);
        owed       = CW'(rem_beats);
        cap        = CW'(MAX_BEAT);
        pick       = (owed < room_beats) ? owed : room_beats;
        if (cap < pick) begin
            pick = cap;
        end
        beats = BEAT_W'(pick);
    end
endmodule

// File: rtl/bsplit_seq.sv
// Transfer state: current command address, beats still owed, size code,
// plus the done and error pulses. Assumes req_fire and cmd_fire never
// occur together, because a request is only taken while idle.
module bsplit_seq
    import bsplit_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_fire,
    input  logic              req_ok,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CNT_W-1:0]  req_bytes,
    input  logic [2:0]        req_size,
    input  logic              cmd_fire,
    input  logic [BEAT_W-1:0] beats,
    output logic              busy,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CNT_W-1:0]  rem_beats,
    output logic [2:0]        cur_size,
    output logic              done,
    output logic              err
);
    // Load a new transfer, or advance past the command just accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            cur_addr  <= '0;
            rem_beats <= '0;
            cur_size  <= '0;
            done      <= 1'b0;
            err       <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            if (req_fire) begin
                if (req_ok) begin
                    busy      <= 1'b1;
                    cur_addr  <= req_addr;
                    rem_beats <= req_bytes >> req_size;
                    cur_size  <= req_size;
                end else begin
                    err <= 1'b1;
                end
            end else if (cmd_fire) begin
                cur_addr  <= cur_addr + (ADDR_W'(beats) << cur_size);
                rem_beats <= rem_beats - CNT_W'(beats);
                if (rem_beats == CNT_W'(beats)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/burst_splitter4k.sv
// Top of the burst splitter. Takes one request while idle and issues
// incrementing burst commands that never cross a 4 KB page and never exceed
// the beat cap of the mode (256 beats when LONG_MODE=1, otherwise 16).
// Assumes ADDR_W >= 13 and 9 <= CNT_W.
module burst_splitter4k
    import bsplit_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int CNT_W     = 16,
    parameter bit LONG_MODE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CNT_W-1:0]  req_bytes,
    input  logic [2:0]        req_size,
    output logic              req_err,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [LEN_W-1:0]  cmd_len,
    output logic [2:0]        cmd_size,
    output logic [1:0]        cmd_burst,
    output logic              done
);
    logic              busy;
    logic              req_ok;
    logic              req_fire;
    logic              cmd_fire;
    logic [ADDR_W-1:0] cur_addr;
    logic [CNT_W-1:0]  rem_beats;
    logic [2:0]        cur_size;
    logic [BEAT_W-1:0] beats;

    bsplit_req_check #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_check (
        .addr  (req_addr),
        .bytes (req_bytes),
        .size  (req_size),
        .ok    (req_ok)
    );

    bsplit_beat_calc #(.CNT_W(CNT_W), .LONG_MODE(LONG_MODE)) u_calc (
        .page_off  (cur_addr[PAGE_BITS-1:0]),
        .rem_beats (rem_beats),
        .size      (cur_size),
        .beats     (beats)
    );

    bsplit_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_fire  (req_fire),
        .req_ok    (req_ok),
        .req_addr  (req_addr),
        .req_bytes (req_bytes),
        .req_size  (req_size),
        .cmd_fire  (cmd_fire),
        .beats     (beats),
        .busy      (busy),
        .cur_addr  (cur_addr),
        .rem_beats (rem_beats),
        .cur_size  (cur_size),
        .done      (done),
        .err       (req_err)
    );

    // Handshakes and command fields come straight from the held state.
    always_comb begin
        req_ready = !busy;
        req_fire  = req_valid && !busy;
        cmd_valid = busy;
        cmd_fire  = busy && cmd_ready;
        cmd_addr  = cur_addr;
        cmd_len   = LEN_W'(beats - BEAT_W'(1));
        cmd_size  = cur_size;
        cmd_burst = BURST_INCR;
    end
endmodule

// File: rtl/bsplit_checker.sv
// Protocol checker for burst_splitter4k, attached with bind below.
module bsplit_checker
    import bsplit_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter bit LONG_MODE = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              req_err,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic [LEN_W-1:0]  cmd_len,
    input logic [2:0]        cmd_size,
    input logic [1:0]        cmd_burst,
    input logic              done
);
    localparam int CAP_LEN = int'(beat_cap(LONG_MODE)) - 1;

    logic [16:0] span_bytes;
    logic [16:0] page_end;

    // Bytes covered by the present command, and where it ends within its page.
    always_comb begin
        span_bytes = 17'({1'b0, cmd_len} + 9'd1) << cmd_size;
        page_end   = 17'(cmd_addr[PAGE_BITS-1:0]) + span_bytes;
    end

    p_no_cross_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> page_end <= 17'(PAGE_BYTES));

    p_incr_type_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> cmd_burst == 2'b01);

    p_len_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> int'(cmd_len) <= CAP_LEN);

    p_contiguous_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=>
            (!cmd_valid || cmd_addr == $past(cmd_addr) + ADDR_W'($past(span_bytes))));

    p_busy_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !req_ready);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=>
            (cmd_valid && $stable(cmd_addr) && $stable(cmd_len) && $stable(cmd_size)));

    p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!cmd_valid && req_ready));

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_err_nocmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> !cmd_valid);
endmodule

bind burst_splitter4k bsplit_checker #(.ADDR_W(ADDR_W), .LONG_MODE(LONG_MODE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .req_err   (req_err),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_addr  (cmd_addr),
    .cmd_len   (cmd_len),
    .cmd_size  (cmd_size),
    .cmd_burst (cmd_burst),
    .done      (done)
);

// File: tb/tb_burst_splitter4k.sv
module tb_burst_splitter4k;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_v = 1'b0;
    logic        cmd_rdy = 1'b0;
    logic        sel_r = 1'b0;
    logic [31:0] req_addr = '0;
    logic [15:0] req_bytes = '0;
    logic [2:0]  req_size = '0;

    logic        d_req_ready, d_req_err, d_cmd_valid, d_done;
    logic [31:0] d_cmd_addr;
    logic [7:0]  d_cmd_len;
    logic [2:0]  d_cmd_size;
    logic [1:0]  d_cmd_burst;
    logic        l_req_ready, l_req_err, l_cmd_valid, l_done;
    logic [31:0] l_cmd_addr;
    logic [7:0]  l_cmd_len;
    logic [2:0]  l_cmd_size;
    logic [1:0]  l_cmd_burst;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    burst_splitter4k dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_v && !sel_r), .req_ready(d_req_ready),
        .req_addr(req_addr), .req_bytes(req_bytes), .req_size(req_size), .req_err(d_req_err),
        .cmd_valid(d_cmd_valid), .cmd_ready(cmd_rdy && !sel_r), .cmd_addr(d_cmd_addr),
        .cmd_len(d_cmd_len), .cmd_size(d_cmd_size), .cmd_burst(d_cmd_burst), .done(d_done)
    );

    burst_splitter4k #(.LONG_MODE(1'b0)) dut_legacy (
        .clk(clk), .rst_n(rst_n), .req_valid(req_v && sel_r), .req_ready(l_req_ready),
        .req_addr(req_addr), .req_bytes(req_bytes), .req_size(req_size), .req_err(l_req_err),
        .cmd_valid(l_cmd_valid), .cmd_ready(cmd_rdy && sel_r), .cmd_addr(l_cmd_addr),
        .cmd_len(l_cmd_len), .cmd_size(l_cmd_size), .cmd_burst(l_cmd_burst), .done(l_done)
    );

    wire        m_req_ready = sel_r ? l_req_ready : d_req_ready;
    wire        m_req_err   = sel_r ? l_req_err   : d_req_err;
    wire        m_cmd_valid = sel_r ? l_cmd_valid : d_cmd_valid;
    wire        m_done      = sel_r ? l_done      : d_done;
    wire [31:0] m_cmd_addr  = sel_r ? l_cmd_addr  : d_cmd_addr;
    wire [7:0]  m_cmd_len   = sel_r ? l_cmd_len   : d_cmd_len;
    wire [2:0]  m_cmd_size  = sel_r ? l_cmd_size  : d_cmd_size;
    wire [1:0]  m_cmd_burst = sel_r ? l_cmd_burst : d_cmd_burst;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    // Drives one transfer and compares each command with the R6/R7 model.
    // stall: hold cmd_ready low for one cycle on every command (R10).
    // poke: offer a stray request while busy (R9).
    task automatic run_xfer(input bit sel, input logic [31:0] a0, input logic [15:0] nb,
                            input logic [2:0] sz, input bit stall, input bit poke);
        logic [31:0] a;
        int rem, eb, room, maxb, guard, total;
        bit held;
        sel_r = sel;
        a = a0; rem = int'(nb >> sz); maxb = sel ? 16 : 256;
        held = 1'b0; guard = 0; total = 0;
        @(negedge clk);
        chk(m_req_ready == 1'b1, "R9", "ready while idle", m_req_ready, 1);
        req_addr = a0; req_bytes = nb; req_size = sz; req_v = 1'b1;
        @(negedge clk);
        req_v = 1'b0;
        while (rem > 0 && guard < 5000) begin
            guard++;
            if (poke) begin
                req_v = 1'b1; req_addr = 32'h0000_5000; req_bytes = 16'd4; req_size = 3'd0;
                chk(m_req_ready == 1'b0, "R9", "ready while busy", m_req_ready, 0);
            end
            room = (4096 - int'(a[11:0])) >> sz;
            eb = rem;
            if (room < eb) eb = room;
            if (maxb < eb) eb = maxb;
            if (!m_cmd_valid) begin
                chk(1'b0, "R7", "cmd_valid missing", 0, 1);
                cmd_rdy = 1'b0;
            end else begin
                chk(m_cmd_addr == a, "R1 R7 R10", "cmd_addr", m_cmd_addr, a);
                chk(int'(m_cmd_len) == eb - 1, "R6 R3 R4 R5", "cmd_len", m_cmd_len, eb - 1);
                chk(m_cmd_size == sz && m_cmd_burst == 2'b01, "R2", "size/burst",
                    {m_cmd_size, m_cmd_burst}, {sz, 2'b01});
                if (stall && !held) begin
                    cmd_rdy = 1'b0; held = 1'b1;
                end else begin
                    cmd_rdy = 1'b1; held = 1'b0;
                    a = a + (32'(eb) << sz); rem = rem - eb; total++;
                end
            end
            @(negedge clk);
        end
        cmd_rdy = 1'b0; req_v = 1'b0;
        chk(m_done == 1'b1 && m_cmd_valid == 1'b0, "R11", "done after last",
            {m_done, m_cmd_valid}, 2'b10);
        @(negedge clk);
        chk(m_done == 1'b0, "R11", "done one cycle", m_done, 0);
        sel_r = 1'b0;
    endtask

    // Offers a request that must be refused with a single req_err pulse.
    task automatic run_bad(input logic [31:0] a0, input logic [15:0] nb, input logic [2:0] sz);
        @(negedge clk);
        req_addr = a0; req_bytes = nb; req_size = sz; req_v = 1'b1;
        @(negedge clk);
        req_v = 1'b0;
        chk(d_req_err == 1'b1 && d_cmd_valid == 1'b0, "R8", "refused request",
            {d_req_err, d_cmd_valid}, 2'b10);
        @(negedge clk);
        chk(d_req_err == 1'b0 && d_cmd_valid == 1'b0 && d_req_ready == 1'b1, "R8",
            "after refusal", {d_req_err, d_cmd_valid, d_req_ready}, 3'b001);
    endtask

    typedef struct packed {
        logic [31:0] a;
        logic [15:0] n;
        logic [2:0]  s;
        logic        st;
    } vec_t;

    // addr, bytes, size, stall
    localparam vec_t VECS [8] = '{
        '{32'h0000_1000, 16'd16,   3'd2, 1'b0},  // R5 single command
        '{32'h0000_0FF0, 16'd32,   3'd2, 1'b1},  // R1 cut at page end
        '{32'h0000_0000, 16'd2048, 3'd2, 1'b0},  // R3 two 256-beat commands
        '{32'h0000_0F00, 16'd1024, 3'd3, 1'b1},  // R1 R6 page cut then remainder
        '{32'h0000_2000, 16'd4096, 3'd4, 1'b0},  // R3 R5 256 beats ending on a boundary
        '{32'h0000_0FFC, 16'd8,    3'd2, 1'b0},  // R1 one beat on each side of the boundary
        '{32'h0000_0003, 16'd3,    3'd0, 1'b0},  // R5 byte beats, odd address
        '{32'h1FFF_FF80, 16'h2000, 3'd3, 1'b1}   // R6 page and cap cuts in turn
    };

    initial begin
        repeat (3) @(negedge clk);
        chk(d_cmd_valid == 1'b0 && d_done == 1'b0 && d_req_err == 1'b0, "R9",
            "reset outputs", {d_cmd_valid, d_done, d_req_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(d_req_ready == 1'b1 && d_cmd_valid == 1'b0, "R9", "idle after reset",
            {d_req_ready, d_cmd_valid}, 2'b10);

        foreach (VECS[i]) begin
            run_xfer(1'b0, VECS[i].a, VECS[i].n, VECS[i].s, VECS[i].st, 1'b0);
        end

        run_bad(32'h0000_1002, 16'd16, 3'd2);  // R8 address not aligned
        run_bad(32'h0000_1000, 16'd18, 3'd2);  // R8 byte count not aligned
        run_bad(32'h0000_1000, 16'd0,  3'd0);  // R8 zero bytes

        run_xfer(1'b0, 32'h0000_3F80, 16'd512, 3'd2, 1'b0, 1'b1);  // R9 stray request while busy
        run_xfer(1'b1, 32'h0000_0000, 16'd128, 3'd2, 1'b0, 1'b0);  // R4 legacy: two 16-beat commands
        run_xfer(1'b1, 32'h0000_0FE0, 16'd96,  3'd1, 1'b1, 1'b0);  // R4 legacy with page cut

        report();
    end
endmodule